// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Filter

This block compares two pulse trains that come out of a synthesizer's dividers: a divided reference pulse and a divided feedback pulse. Both inputs are sampled by a fast clock. The detector is three-state. The leading rising edge raises one pump request. The lagging edge raises the other. One cycle after both requests are up, both are cleared together. A polarity bit swaps the two pump controls, so that oscillators whose tuning slope is positive and those whose slope is negative are both served.

While the loop is settled, the pump stays idle apart from brief correction pulses, and an idle flag reports that idle state. A current-range bit is forwarded unchanged to the analog pump.

A lock filter measures the phase error of each comparison. The error is the number of sampling cycles in which exactly one request is active. Lock is declared only after a run of consecutive comparisons whose error stays under a window. A multifunction status pin can show the lock result, either divider pulse, or a fixed level.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is held and right after it is released, both pump controls are low, the idle flag is high and the lock result is low.
- R2: With polarity 0, when the reference edge leads the feedback edge by d cycles, pump_up is high for d+1 cycles, starting after the edge that samples the reference high. pump_dn is high for exactly 1 cycle, the last of those cycles.
- R3: With polarity 0, when the feedback edge leads by d cycles, pump_dn is high for d+1 cycles and pump_up is high for 1 cycle. Edges sampled in the same cycle give a single cycle on each output.
- R4: With polarity 1, the roles of pump_up and pump_dn are exchanged for every pattern.
- R5: pump_hiz is high exactly when neither pump control is high.
- R6: gain_out always equals gain_hi.
- R7: A comparison is good when its error is below WIN_CYC cycles (default 4). The lock result goes high once GOOD_NEED (default 4) consecutive comparisons have been good. The update happens on the edge that clears both requests.
- R8: A comparison whose error is WIN_CYC cycles or more resets the run of good comparisons to zero and drops the lock result.
- R9: pin_sel selects the status pin source: 2'b00 gives the lock result, 2'b01 gives ref_pulse, 2'b10 gives fb_pulse, and 2'b11 gives pin_level. pin_level has no effect under any other selection.
- R10: A divider edge sampled on the same edge that clears both requests is not lost. It raises its request for the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | Divided reference pulse |
| fb_pulse | input | 1 | Divided feedback pulse |
| pol_invert | input | 1 | 1 swaps pump_up and pump_dn |
| gain_hi | input | 1 | Charge-pump current range select |
| pin_sel | input | 2 | Status pin source select |
| pin_level | input | 1 | Fixed level for the status pin |
| pump_up | output | 1 | Pump-up control |
| pump_dn | output | 1 | Pump-down control |
| pump_hiz | output | 1 | High when the pump is idle |
| gain_out | output | 1 | Forwarded current range select |
| status_pin | output | 1 | Multifunction status output |

## Verification
Two things can happen on the same edge: the detector clears both requests, and a new divider edge arrives and opens the next comparison. The lock filter also closes its evaluation on that edge. The bench provokes the overlap by sending a fresh reference pulse so that it is sampled on the clear edge. It then checks that pump_up is high alone in the following cycle, and that the next feedback edge closes that comparison normally.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PIN_LOCK  = 2'b00,
        PIN_REF   = 2'b01,
        PIN_FB    = 2'b10,
        PIN_LEVEL = 2'b11
    } pin_sel_e;

    typedef struct packed {
        logic ref_prev;
        logic fb_prev;
        logic up;
        logic dn;
    } det_state_t;

endpackage

// File: rtl/pfd_core.sv
module pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o
);
    import pfd_pkg::*;

    det_state_t st_d, st_q;
    logic ref_rise, fb_rise;

    always_comb begin
        ref_rise = ref_i & ~st_q.ref_prev;
        fb_rise  = fb_i & ~st_q.fb_prev;
        st_d = st_q;
        st_d.ref_prev = ref_i;
        st_d.fb_prev  = fb_i;
        if (st_q.up && st_q.dn) begin
            // both requests clear; an edge seen now opens the next comparison
            st_d.up = ref_rise;
            st_d.dn = fb_rise;
        end else begin
            st_d.up = st_q.up | ref_rise;
            st_d.dn = st_q.dn | fb_rise;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
    parameter int WIN_CYC   = 4,
    parameter int GOOD_NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    output logic lock_o
);
    localparam int ERR_W  = $clog2(WIN_CYC + 1);
    localparam int GOOD_W = $clog2(GOOD_NEED + 1);
    localparam logic [ERR_W-1:0]  ERR_MAX  = ERR_W'(WIN_CYC);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(GOOD_NEED);

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [GOOD_W-1:0] good;
    } filt_state_t;

    filt_state_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (up_i && dn_i) begin
            // comparison ends: judge its accumulated error
            if (fs_q.err < ERR_MAX) begin
                if (fs_q.good != GOOD_MAX) fs_d.good = fs_q.good + 1'b1;
            end else begin
                fs_d.good = '0;
            end
            fs_d.err = '0;
        end else if (up_i ^ dn_i) begin
            if (fs_q.err != ERR_MAX) fs_d.err = fs_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign lock_o = (fs_q.good == GOOD_MAX);
endmodule

// File: rtl/pfd_pin_mux.sv
module pfd_pin_mux (
    input  pfd_pkg::pin_sel_e sel_i,
    input  logic              lock_i,
    input  logic              ref_i,
    input  logic              fb_i,
    input  logic              level_i,
    output logic              pin_o
);
    import pfd_pkg::*;

    always_comb begin
        unique case (sel_i)
            PIN_LOCK:  pin_o = lock_i;
            PIN_REF:   pin_o = ref_i;
            PIN_FB:    pin_o = fb_i;
            PIN_LEVEL: pin_o = level_i;
            default:   pin_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
    parameter int WIN_CYC   = 4,
    parameter int GOOD_NEED = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_pulse,
    input  logic       fb_pulse,
    input  logic       pol_invert,
    input  logic       gain_hi,
    input  logic [1:0] pin_sel,
    input  logic       pin_level,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hiz,
    output logic       gain_out,
    output logic       status_pin
);
    import pfd_pkg::*;

    logic up_w, dn_w, lock_w;

    pfd_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_i (ref_pulse),
        .fb_i  (fb_pulse),
        .up_o  (up_w),
        .dn_o  (dn_w)
    );

    pfd_lock_filter #(
        .WIN_CYC   (WIN_CYC),
        .GOOD_NEED (GOOD_NEED)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_i   (up_w),
        .dn_i   (dn_w),
        .lock_o (lock_w)
    );

    pfd_pin_mux u_mux (
        .sel_i   (pin_sel_e'(pin_sel)),
        .lock_i  (lock_w),
        .ref_i   (ref_pulse),
        .fb_i    (fb_pulse),
        .level_i (pin_level),
        .pin_o   (status_pin)
    );

    assign pump_up  = pol_invert ? dn_w : up_w;
    assign pump_dn  = pol_invert ? up_w : dn_w;
    assign pump_hiz = ~(up_w | dn_w);
    assign gain_out = gain_hi;
endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_pulse,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       pump_hiz,
    input logic       lock,
    input logic [1:0] pin_sel,
    input logic       pin_level,
    input logic       status_pin
);
    logic ref_seen_q;
    logic ref_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) ref_seen_q <= 1'b0;
        else        ref_seen_q <= ref_pulse;
    end
    assign ref_edge = ref_pulse & ~ref_seen_q;

    AST_REF_EDGE_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> (pump_up || pump_dn)); // R2

    AST_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn && !ref_edge) |=> !(pump_up && pump_dn)); // R3

    AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pump_hiz |-> (!pump_up && !pump_dn)); // R5

    AST_LOCK_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(pump_up && pump_dn)); // R7

    AST_LOCK_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(pump_up && pump_dn)); // R8

    AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == 2'b11) |-> (status_pin == pin_level)); // R9
endmodule

bind pfd_lock_top pfd_lock_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_pulse  (ref_pulse),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .pump_hiz   (pump_hiz),
    .lock       (lock_w),
    .pin_sel    (pin_sel),
    .pin_level  (pin_level),
    .status_pin (status_pin)
);

// File: tb/tb_pfd_lock_top.sv
`timescale 1ns/1ps
module tb_pfd_lock_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, fb_pulse = 1'b0, pol_invert = 1'b0, gain_hi = 1'b0;
    logic [1:0] pin_sel = 2'b00;
    logic pin_level = 1'b0;
    logic pump_up, pump_dn, pump_hiz, gain_out, status_pin;

    int n_run = 0, n_fail = 0, hiz_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfd_lock_top dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .pol_invert(pol_invert), .gain_hi(gain_hi), .pin_sel(pin_sel),
        .pin_level(pin_level), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .gain_out(gain_out), .status_pin(status_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        ref_pulse = 0; fb_pulse = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // one comparison: leader pulse at step 0, lagger pulse at step d
    task automatic run_cmp(input bit ref_first, input int d, output int wu, output int wd);
        wu = 0; wd = 0;
        for (int i = 0; i < d + 6; i++) begin
            ref_pulse = ref_first ? (i == 0) : (i == d);
            fb_pulse  = ref_first ? (i == d) : (i == 0);
            @(negedge clk);
            if (pump_up) wu++;
            if (pump_dn) wd++;
            if (pump_hiz != !(pump_up || pump_dn)) hiz_bad++;
        end
        ref_pulse = 0; fb_pulse = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; pin_sel = 2'b00;
        repeat (2) @(negedge clk);
        check("R1 up in reset", pump_up, 0);
        check("R1 dn in reset", pump_dn, 0);
        check("R1 hiz in reset", pump_hiz, 1);
        rst_n = 1;
        @(negedge clk);
        check("R1 lock after reset", status_pin, 0);
    endtask

    task automatic t_patterns();
        int wu, wd;
        do_reset(); pol_invert = 0;
        run_cmp(1, 3, wu, wd);
        check("R2 up width ref lead", wu, 4);
        check("R2 dn width ref lead", wd, 1);
        run_cmp(0, 3, wu, wd);
        check("R3 dn width fb lead", wd, 4);
        check("R3 up width fb lead", wu, 1);
        run_cmp(1, 0, wu, wd);
        check("R3 simultaneous up", wu, 1);
        check("R3 simultaneous dn", wd, 1);
        pol_invert = 1;
        run_cmp(1, 3, wu, wd);
        check("R4 swapped dn width", wd, 4);
        check("R4 swapped up width", wu, 1);
        run_cmp(0, 2, wu, wd);
        check("R4 swapped up width fb lead", wu, 3);
        pol_invert = 0;
        check("R5 idle flag mismatches", hiz_bad, 0);
        check("R5 idle flag high at rest", pump_hiz, 1);
    endtask

    task automatic t_gain();
        gain_hi = 1; #1;
        check("R6 gain high", gain_out, 1);
        gain_hi = 0; #1;
        check("R6 gain low", gain_out, 0);
    endtask

    task automatic t_lock();
        int wu, wd;
        do_reset(); pin_sel = 2'b00;
        for (int k = 0; k < 3; k++) run_cmp(1, 3, wu, wd);
        check("R7 no lock after 3 good", status_pin, 0);
        run_cmp(0, 3, wu, wd);
        check("R7 lock after 4 good (error 3)", status_pin, 1);
        run_cmp(1, 4, wu, wd);
        check("R8 lock dropped at error 4", status_pin, 0);
        for (int k = 0; k < 3; k++) run_cmp(1, 1, wu, wd);
        check("R8 run restarted, 3 good", status_pin, 0);
        run_cmp(1, 0, wu, wd);
        check("R7 relock", status_pin, 1);
        run_cmp(0, 6, wu, wd);
        check("R8 large fb-lead error drops lock", status_pin, 0);
    endtask

    task automatic t_pin();
        pin_sel = 2'b01; ref_pulse = 1; fb_pulse = 0; #1;
        check("R9 sel 01 ref high", status_pin, 1);
        ref_pulse = 0; #1;
        check("R9 sel 01 ref low", status_pin, 0);
        pin_sel = 2'b10; fb_pulse = 1; #1;
        check("R9 sel 10 fb high", status_pin, 1);
        fb_pulse = 0; #1;
        pin_sel = 2'b11; pin_level = 1; #1;
        check("R9 sel 11 level high", status_pin, 1);
        pin_level = 0; #1;
        check("R9 sel 11 level low", status_pin, 0);
        pin_sel = 2'b00; pin_level = 1; #1;
        check("R9 level ignored under sel 00", status_pin, 0);
        pin_level = 0;
        @(negedge clk);
    endtask

    task automatic t_overlap();
        do_reset(); pol_invert = 0;
        ref_pulse = 1; @(negedge clk);
        ref_pulse = 0; fb_pulse = 1; @(negedge clk);
        check("R10 both up before clear", pump_up & pump_dn, 1);
        ref_pulse = 1; fb_pulse = 0; @(negedge clk);
        check("R10 edge at clear raises up", pump_up, 1);
        check("R10 dn cleared", pump_dn, 0);
        ref_pulse = 0; fb_pulse = 1; @(negedge clk);
        check("R10 next comparison closes", pump_up & pump_dn, 1);
        fb_pulse = 0; @(negedge clk);
        check("R10 idle after second clear", pump_hiz, 1);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_gain();
        t_lock();
        t_pin();
        t_overlap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule